// File: doc/BRIEF.md
# Hamming SEC-DED Codec

This block protects a data word with a single-error-correcting, double-error-detecting Hamming code. The encoder side is purely combinational: a data word on `enc_data_i` appears as a complete code word on `enc_code_o` in the same cycle. The decoder side takes a received code word with a one-cycle valid strobe. One clock later it presents the repaired data word, together with exactly one of three verdict flags: clean, corrected or uncorrectable.

The data width is a parameter. The number of check bits is derived from it, so the default of 4 data bits gives an 8-bit code word and 64 data bits give a 72-bit word. Inside the code word, bit k (for k from 1 upward) carries Hamming position k. Bit 0 carries an overall parity bit over the whole word.

The decoder's output stage is a two-state machine.
- ST_IDLE means no result is being shown.
- ST_EMIT means a result is on the outputs.

Its transitions are as follows.
- T_ACCEPT (ST_IDLE to ST_EMIT) happens on a strobe.
- T_STREAM (ST_EMIT to ST_EMIT) happens on back-to-back strobes.
- T_DRAIN (ST_EMIT to ST_IDLE) happens when no strobe arrives.

Top module: `secded_codec`

## Requirements
- R1: Code word bit k, for k = 1..N, holds Hamming position k. Positions that are powers of two hold check bits, and the remaining positions take data bits in ascending order starting from data bit 0. For 4 data bits, data bits 0..3 sit at code bits 3, 5, 6 and 7, and check bits sit at code bits 1, 2 and 4.
- R2: The check bit at position 2^j gives even parity over all positions whose index has bit j set. Code bit 0 makes the parity of the whole code word even.
- R3: The check-bit count P is the smallest value with 2^P >= P + D + 1, and the code word is D + P + 1 bits wide. The default D = 4 gives 8 bits.
- R4: A received word with no flipped bit yields the clean flag and the original data.
- R5: A single flipped bit at any position 1..N yields the corrected flag and the original data. The syndrome equals the flipped position, so a received 7-bit body of 1111110 (positions 1..7) with odd overall parity decodes to data 1111.
- R6: A flip of code bit 0 alone yields the corrected flag and unchanged data.
- R7: Any two flipped bits yield the uncorrectable flag. In that case the data output is the received data bits, passed through unrepaired.
- R8: A result appears on the outputs exactly one clock after its `dec_valid_i` strobe, with `dec_valid_o` high for that cycle. Back-to-back strobes give back-to-back results. Without a strobe, `dec_valid_o` and all flags are low, and `dec_data_o` holds its last value.
- R9: While `dec_valid_o` is high, exactly one of the three flags is high.
- R10: While reset is applied, `dec_valid_o`, `dec_data_o` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_code_o | output | CODE_W | Encoded word, same cycle |
| dec_valid_i | input | 1 | Strobe: dec_code_i holds a word to decode |
| dec_code_i | input | CODE_W | Received code word |
| dec_valid_o | output | 1 | Decode result present this cycle |
| dec_data_o | output | DATA_W | Repaired (or passed-through) data |
| dec_clean_o | output | 1 | No error found |
| dec_fixed_o | output | 1 | Single error repaired (including code bit 0 alone) |
| dec_fatal_o | output | 1 | Double error, data not repaired |

## Verification
Every test word is encoded and compared with a bench-side model of the parity equations, and is then fed back to the decoder with a chosen flip mask.

The masks cover four cases:
- no flip, which separates clean words from everything else;
- single flips on data bits and on check bits, which prove that the syndrome points to the right position;
- a flip of bit 0 alone, which must be reported as corrected without touching the data;
- pairs of flips, including a pair made of one position bit and bit 0, which must be reported as uncorrectable with the raw data passed through.

Directed steps cover the reset state, the worked 1111110 example, and back-to-back strobes followed by an idle cycle, which shows that the flags drop while the data holds.

// File: rtl/secded_pkg.sv
package secded_pkg;

    // Smallest check-bit count p with 2^p >= p + d + 1
    function automatic int parity_bits(input int d);
        for (int p = 1; p < 31; p++) begin
            if ((1 << p) >= p + d + 1) return p;
        end
        return 31;
    endfunction

    function automatic bit is_pow2(input int i);
        return (i > 0) && ((i & (i - 1)) == 0);
    endfunction

    // Data bit held at non-power-of-two position i
    function automatic int data_index(input int i);
        return i - $clog2(i + 1) - 1;
    endfunction

    typedef enum logic [1:0] {
        CLS_CLEAN = 2'd0,
        CLS_FIXED = 2'd1,
        CLS_FATAL = 2'd2
    } verdict_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
#(
    parameter int DATA_W = 4,
    localparam int PAR_W  = parity_bits(DATA_W),
    localparam int POS_N  = DATA_W + PAR_W,
    localparam int CODE_W = POS_N + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic [POS_N:1]            placed;
    logic [PAR_W-1:0][POS_N:1] group;
    logic [PAR_W-1:0]          chk;
    logic [POS_N:1]            body;

    // Data bits into non-power-of-two positions
    for (genvar gi = 1; gi <= POS_N; gi++) begin : g_place
        if (is_pow2(gi)) begin : g_hole
            assign placed[gi] = 1'b0;
        end else begin : g_bit
            assign placed[gi] = data_i[data_index(gi)];
        end
    end

    // Each check bit covers positions whose index has bit j set
    for (genvar gj = 0; gj < PAR_W; gj++) begin : g_chk
        for (genvar gi = 1; gi <= POS_N; gi++) begin : g_sel
            if (((gi >> gj) & 1) == 1) begin : g_in
                assign group[gj][gi] = placed[gi];
            end else begin : g_out
                assign group[gj][gi] = 1'b0;
            end
        end
        assign chk[gj] = ^group[gj];
    end

    for (genvar gi = 1; gi <= POS_N; gi++) begin : g_body
        if (is_pow2(gi)) begin : g_p
            assign body[gi] = chk[$clog2(gi)];
        end else begin : g_d
            assign body[gi] = placed[gi];
        end
    end

    assign code_o = {body, ^body};

endmodule

// File: rtl/secded_check.sv
module secded_check
    import secded_pkg::*;
#(
    parameter int DATA_W = 4,
    localparam int PAR_W  = parity_bits(DATA_W),
    localparam int POS_N  = DATA_W + PAR_W,
    localparam int CODE_W = POS_N + 1
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [PAR_W-1:0]  syndrome_o,
    output logic              odd_o
);

    logic [PAR_W-1:0][POS_N:1] group;

    for (genvar gj = 0; gj < PAR_W; gj++) begin : g_syn
        for (genvar gi = 1; gi <= POS_N; gi++) begin : g_sel
            if (((gi >> gj) & 1) == 1) begin : g_in
                assign group[gj][gi] = code_i[gi];
            end else begin : g_out
                assign group[gj][gi] = 1'b0;
            end
        end
        assign syndrome_o[gj] = ^group[gj];
    end

    assign odd_o = ^code_i;

endmodule

// File: rtl/secded_fix.sv
module secded_fix
    import secded_pkg::*;
#(
    parameter int DATA_W = 4,
    localparam int PAR_W  = parity_bits(DATA_W),
    localparam int POS_N  = DATA_W + PAR_W,
    localparam int CODE_W = POS_N + 1
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [PAR_W-1:0]  syndrome_i,
    input  logic              odd_i,
    output logic [DATA_W-1:0] data_o,
    output verdict_e          verdict_o
);

    logic [POS_N:1] repaired;

    always_comb begin
        repaired  = code_i[POS_N:1];
        verdict_o = CLS_CLEAN;
        unique case ({|syndrome_i, odd_i})
            2'b00: verdict_o = CLS_CLEAN;
            2'b01: verdict_o = CLS_FIXED;          // overall bit alone
            2'b11: begin
                if (syndrome_i <= PAR_W'(POS_N)) begin
                    verdict_o = CLS_FIXED;
                    for (int i = 1; i <= POS_N; i++) begin
                        if (syndrome_i == PAR_W'(i)) repaired[i] = ~repaired[i];
                    end
                end else begin
                    verdict_o = CLS_FATAL;         // points past the word
                end
            end
            default: verdict_o = CLS_FATAL;        // even overall, nonzero syndrome
        endcase
    end

    for (genvar gi = 1; gi <= POS_N; gi++) begin : g_take
        if (!is_pow2(gi)) begin : g_d
            assign data_o[data_index(gi)] = repaired[gi];
        end
    end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter int DATA_W = 4,
    localparam int PAR_W  = parity_bits(DATA_W),
    localparam int POS_N  = DATA_W + PAR_W,
    localparam int CODE_W = POS_N + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_clean_o,
    output logic              dec_fixed_o,
    output logic              dec_fatal_o
);

    logic [PAR_W-1:0]  syndrome;
    logic              odd;
    logic [DATA_W-1:0] fix_data;
    verdict_e          verdict;
    emit_state_e       state_q, state_d;

    secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_o)
    );

    secded_check #(.DATA_W(DATA_W)) u_check (
        .code_i     (dec_code_i),
        .syndrome_o (syndrome),
        .odd_o      (odd)
    );

    secded_fix #(.DATA_W(DATA_W)) u_fix (
        .code_i     (dec_code_i),
        .syndrome_i (syndrome),
        .odd_i      (odd),
        .data_o     (fix_data),
        .verdict_o  (verdict)
    );

    // Next state: T_ACCEPT, T_STREAM, T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (dec_valid_i)  state_d = ST_EMIT;
            ST_EMIT: if (!dec_valid_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_data_o  <= '0;
            dec_clean_o <= 1'b0;
            dec_fixed_o <= 1'b0;
            dec_fatal_o <= 1'b0;
        end else if (dec_valid_i) begin
            dec_data_o  <= fix_data;
            dec_clean_o <= (verdict == CLS_CLEAN);
            dec_fixed_o <= (verdict == CLS_FIXED);
            dec_fatal_o <= (verdict == CLS_FATAL);
        end else begin
            dec_clean_o <= 1'b0;
            dec_fixed_o <= 1'b0;
            dec_fatal_o <= 1'b0;
        end
    end

    assign dec_valid_o = (state_q == ST_EMIT);

    // Received data bits, unrepaired, for the pass-through checks
    logic [DATA_W-1:0] raw_in;
    for (genvar gi = 1; gi <= POS_N; gi++) begin : g_raw
        if (!is_pow2(gi)) begin : g_d
            assign raw_in[data_index(gi)] = dec_code_i[gi];
        end
    end

    a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);

    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> !dec_valid_o);

    a_r8_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_o |-> !(dec_clean_o || dec_fixed_o || dec_fatal_o));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> $stable(dec_data_o));

    a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> $countones({dec_clean_o, dec_fixed_o, dec_fatal_o}) == 1);

    a_r4_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i && (syndrome == '0) && !odd |=> dec_clean_o && (dec_data_o == $past(raw_in)));

    a_r7_fatal_pass: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i && (syndrome != '0) && !odd |=> dec_fatal_o && (dec_data_o == $past(raw_in)));

endmodule

// File: tb/secded_codec_bench.sv
`timescale 1ns/1ps
module secded_codec_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] enc_data_i = '0;
    logic [7:0] enc_code_o;
    logic       dec_valid_i = 1'b0;
    logic [7:0] dec_code_i = '0;
    logic       dec_valid_o;
    logic [3:0] dec_data_o;
    logic       dec_clean_o, dec_fixed_o, dec_fatal_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    secded_codec u_secded_codec (
        .clk(clk), .rst_n(rst_n),
        .enc_data_i(enc_data_i), .enc_code_o(enc_code_o),
        .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_clean_o(dec_clean_o), .dec_fixed_o(dec_fixed_o), .dec_fatal_o(dec_fatal_o)
    );

    // {data[3:0], flip mask[7:0], class[1:0]}; class 0 clean, 1 fixed, 2 fatal
    localparam logic [13:0] VEC [12] = '{
        {4'h0, 8'h00, 2'd0},
        {4'hF, 8'h00, 2'd0},
        {4'hA, 8'h08, 2'd1},
        {4'h5, 8'h80, 2'd1},
        {4'h3, 8'h02, 2'd1},
        {4'hC, 8'h01, 2'd1},
        {4'h9, 8'h28, 2'd2},
        {4'h6, 8'h11, 2'd2},
        {4'h7, 8'h06, 2'd2},
        {4'hE, 8'h10, 2'd1},
        {4'h1, 8'h40, 2'd1},
        {4'hB, 8'h20, 2'd1}
    };

    function automatic logic [7:0] ref_encode(input logic [3:0] d);
        logic [7:0] c;
        c    = '0;
        c[3] = d[0]; c[5] = d[1]; c[6] = d[2]; c[7] = d[3];
        c[1] = c[3] ^ c[5] ^ c[7];
        c[2] = c[3] ^ c[6] ^ c[7];
        c[4] = c[5] ^ c[6] ^ c[7];
        c[0] = ^c[7:1];
        return c;
    endfunction

    function automatic logic [3:0] ref_raw(input logic [7:0] c);
        return {c[7], c[6], c[5], c[3]};
    endfunction

    function automatic logic [2:0] flags_of(input logic [1:0] cls);
        return (cls == 2'd0) ? 3'b100 : (cls == 2'd1) ? 3'b010 : 3'b001;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 valid", 32'(dec_valid_o), 0);
        chk("R10 data", 32'(dec_data_o), 0);
        chk("R10 flags", 32'({dec_clean_o, dec_fixed_o, dec_fatal_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: code word width
        chk("R3 width", 32'($bits(enc_code_o)), 8);

        // Table walk: R1 R2 via encoder, R4 R5 R6 R7 R9 via decoder
        for (int k = 0; k < 12; k++) begin
            logic [3:0] d;
            logic [7:0] m, sent, got;
            logic [1:0] cls;
            d   = VEC[k][13:10];
            m   = VEC[k][9:2];
            cls = VEC[k][1:0];
            enc_data_i = d;
            #1;
            chk("R1 R2 encode", 32'(enc_code_o), 32'(ref_encode(d)));
            sent = ref_encode(d);
            got  = sent ^ m;
            dec_code_i  = got;
            dec_valid_i = 1'b1;
            @(negedge clk);
            dec_valid_i = 1'b0;
            chk("R8 valid", 32'(dec_valid_o), 1);
            if (cls == 2'd0)      chk("R4 flags", 32'({dec_clean_o, dec_fixed_o, dec_fatal_o}), 32'(flags_of(cls)));
            else if (cls == 2'd2) chk("R7 flags", 32'({dec_clean_o, dec_fixed_o, dec_fatal_o}), 32'(flags_of(cls)));
            else if (m == 8'h01)  chk("R6 flags", 32'({dec_clean_o, dec_fixed_o, dec_fatal_o}), 32'(flags_of(cls)));
            else                  chk("R5 flags", 32'({dec_clean_o, dec_fixed_o, dec_fatal_o}), 32'(flags_of(cls)));
            if (cls == 2'd2) chk("R7 data", 32'(dec_data_o), 32'(ref_raw(got)));
            else             chk("R5 R6 data", 32'(dec_data_o), 32'(d));
            chk("R9 one flag", 32'($countones({dec_clean_o, dec_fixed_o, dec_fatal_o})), 1);
            @(negedge clk);
        end

        // R5: worked example, body 1111110, odd overall parity
        dec_code_i  = 8'h7F;
        dec_valid_i = 1'b1;
        @(negedge clk);
        dec_valid_i = 1'b0;
        chk("R5 example data", 32'(dec_data_o), 32'hF);
        chk("R5 example flags", 32'({dec_clean_o, dec_fixed_o, dec_fatal_o}), 32'b010);

        // R8: back-to-back strobes then idle
        @(negedge clk);
        dec_code_i  = ref_encode(4'h2);
        dec_valid_i = 1'b1;
        @(negedge clk);
        chk("R8 first result", 32'({dec_valid_o, dec_data_o, dec_clean_o}), 32'({1'b1, 4'h2, 1'b1}));
        dec_code_i = ref_encode(4'hD) ^ 8'h44;
        @(negedge clk);
        dec_valid_i = 1'b0;
        chk("R8 second result", 32'({dec_valid_o, dec_fatal_o}), 32'b11);
        chk("R8 second data", 32'(dec_data_o), 32'(ref_raw(ref_encode(4'hD) ^ 8'h44)));
        @(negedge clk);
        chk("R8 idle valid", 32'(dec_valid_o), 0);
        chk("R8 idle flags", 32'({dec_clean_o, dec_fixed_o, dec_fatal_o}), 0);
        chk("R8 idle hold", 32'(dec_data_o), 32'(ref_raw(ref_encode(4'hD) ^ 8'h44)));

        finish_run();
    end

endmodule